// File: doc/BRIEF.md
# Asynchronous PSRAM Write Sequencer

This block accepts single write requests from a host over a request/ready handshake and plays each one out as an asynchronous write cycle on a pseudo-static RAM. The cycle is shaped by the write-enable strobe. Each request carries an address, a 16-bit data word and a two-bit byte enable. On the memory side the block drives chip select, write enable, the upper and lower byte selects, the address and a tri-state data bus. Every timing minimum is given in nanoseconds. Each one is turned into a whole number of system-clock cycles by rounding up, with a floor of one cycle, for a configurable clock period.

The block counts how many writes have been issued back to back. Once a continuous run has passed its fiftieth write, every further write uses a longer write-enable pulse. The run counter clears when the host leaves the sequencer idle for a full write-cycle time. The address-valid strobe is held inactive and the memory's wait output is ignored, because neither plays a part in asynchronous writes.

Top module: `psram_wr_seq`

## Requirements
- R1: WE# is low only while CS# is low. CS# falls at least one cycle before WE# falls. The address and byte selects hold steady from the fall of CS# to the end of the write, and CS# stays low for at least ceil(60 ns / period) cycles.
- R2: A write ends with CS# and WE# rising on the same clock edge.
- R3: During a write, host_be bit 0 = 1 drives LB# low and host_be bit 1 = 1 drives UB# low. Both byte selects are high whenever CS# is high.
- R4: ADV# stays high at all times. The mem_wait input has no effect on the timing or values of any output.
- R5: For writes 1 to 50 of a run, the WE# low pulse lasts max(ceil(55/T), ceil(60/T) - setup, ceil(30/T)) cycles. T is the clock period in ns and setup is one cycle at the defaults. This gives 6 cycles at T = 10.
- R6: From the 51st consecutive write onward, the WE# low pulse lasts ceil(70/T) cycles, which is 7 cycles at T = 10.
- R7: The run count clears after ceil(70/T) consecutive cycles (7 at T = 10) in which the sequencer is idle and host_req is low. A shorter idle gap keeps the run going.
- R8: mem_dq carries the write data for at least ceil(30/T) cycles (3 at T = 10) before WE# rises, and for one cycle after. It is high-impedance otherwise.
- R9: host_ready is high only while the sequencer is idle. A request is taken on a rising clock edge where host_req and host_ready are both high. CS# stays high for at least one cycle after each write. With host_req held high at the defaults, successive CS# falling edges are pulse + 4 cycles apart (10 normal, 11 stretched), which is never less than ceil(70/T).
- R10: Out of reset, CS#, WE#, UB# and LB# are high and host_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host write request |
| host_ready | output | 1 | Sequencer idle; a request is taken when this and host_req are both high |
| host_addr | input | ADDR_W | Write address |
| host_data | input | DATA_W | Write data word |
| host_be | input | DATA_W/8 | Byte enables; bit 0 is the low byte, bit 1 the high byte |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, held inactive (high) |
| mem_wait | input | 1 | Memory wait output, ignored |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | DATA_W | Memory data bus, driven only around the end of a write |

## Verification
Some rules hold on every cycle, and the assertions check these. WE# is low only inside CS#, and CS# leads WE#. The address and byte selects hold steady during a write. Both strobes rise together, CS# stays high for a recovery cycle, ready stays low while the bus is busy, and the pulse never falls below the normal minimum. Other behaviour can only be seen across a scenario, and the bench checks that. It covers the exact pulse length on the 50th and 51st writes of a run, and the run surviving a six-cycle idle gap but clearing after seven. It also checks the byte-select patterns for each enable value, the spacing of back-to-back cycles, the data window on the bus, and timing that does not change while mem_wait toggles.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_PULSE,
      ST_HOLD,
      ST_RECOV
   } wr_state_e;

   // nanoseconds to clock cycles, rounded up, never below one cycle
   function automatic int ns_to_cyc(input int ns, input int period_ns);
      int c;
      c = (ns + period_ns - 1) / period_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psram_run_tracker.sv
module psram_run_tracker #(
   parameter int RUN_LIMIT = 50,
   parameter int IDLE_CLR  = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic idle,
   output logic long_o
);
   localparam int RUN_W  = $clog2(RUN_LIMIT + 2);
   localparam int IDLE_W = $clog2(IDLE_CLR + 1);

   generate
      if (RUN_LIMIT == 0) begin : g_no_stretch
         logic unused_in;
         assign unused_in = accept ^ idle;
         assign long_o    = 1'b0;
      end else begin : g_track
         logic [RUN_W-1:0]  run_cnt;
         logic [IDLE_W-1:0] idle_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_cnt  <= '0;
               idle_cnt <= '0;
            end else if (accept) begin
               if (run_cnt != RUN_W'(RUN_LIMIT))
                  run_cnt <= run_cnt + 1'b1;
               idle_cnt <= '0;
            end else if (idle) begin
               if (idle_cnt == IDLE_W'(IDLE_CLR - 1)) begin
                  run_cnt  <= '0;
                  idle_cnt <= '0;
               end else begin
                  idle_cnt <= idle_cnt + 1'b1;
               end
            end else begin
               idle_cnt <= '0;
            end
         end

         // run_cnt counts earlier writes of the run: write n sees n-1
         assign long_o = (run_cnt == RUN_W'(RUN_LIMIT));
      end
   endgenerate

endmodule

// File: rtl/psram_wr_fsm.sv
module psram_wr_fsm
   import psram_wr_pkg::*;
#(
   parameter int SETUP_CYC = 1,
   parameter int PULSE_N   = 6,
   parameter int PULSE_L   = 7,
   parameter int HOLD_CYC  = 1,
   parameter int RECOV_CYC = 1,
   parameter int DV_CYC    = 3,
   parameter int CNT_W     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic long_i,
   output logic ready,
   output logic accept,
   output logic cs_n,
   output logic we_n,
   output logic sel_en,
   output logic dq_oe
);
   wr_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic             long_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         long_q <= 1'b0;
      end else if (state == ST_IDLE) begin
         if (req) begin
            state  <= ST_SETUP;
            cnt    <= CNT_W'(SETUP_CYC - 1);
            long_q <= long_i;
         end
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end else begin
         case (state)
            ST_SETUP: begin
               state <= ST_PULSE;
               cnt   <= long_q ? CNT_W'(PULSE_L - 1) : CNT_W'(PULSE_N - 1);
            end
            ST_PULSE: begin
               state <= ST_HOLD;
               cnt   <= CNT_W'(HOLD_CYC - 1);
            end
            ST_HOLD: begin
               state <= ST_RECOV;
               cnt   <= CNT_W'(RECOV_CYC - 1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ready  = (state == ST_IDLE);
      accept = ready && req;
      sel_en = (state == ST_SETUP) || (state == ST_PULSE);
      cs_n   = !sel_en;
      we_n   = (state != ST_PULSE);
      dq_oe  = ((state == ST_PULSE) && (cnt < CNT_W'(DV_CYC))) || (state == ST_HOLD);
   end

endmodule

// File: rtl/psram_wr_bus.sv
module psram_wr_bus #(
   parameter int ADDR_W = 23,
   parameter int DATA_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   data_i,
   input  logic [DATA_W/8-1:0] be_i,
   input  logic                sel_en,
   input  logic                dq_oe,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] lane_sel_n,
   inout  wire  [DATA_W-1:0]   mem_dq
);
   localparam int LANES = DATA_W / 8;

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [LANES-1:0]  be_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         be_q   <= '0;
      end else if (load) begin
         addr_q <= addr_i;
         data_q <= data_i;
         be_q   <= be_i;
      end
   end

   genvar i;
   generate
      for (i = 0; i < LANES; i++) begin : g_lane
         assign lane_sel_n[i] = !(sel_en && be_q[i]);
      end
   endgenerate

   assign mem_addr = addr_q;
   assign mem_dq   = dq_oe ? data_q : {DATA_W{1'bz}};

endmodule

// File: rtl/psram_wr_seq.sv
module psram_wr_seq
   import psram_wr_pkg::*;
#(
   parameter int ADDR_W        = 23,
   parameter int DATA_W        = 16,
   parameter int CLK_PERIOD_NS = 10,
   parameter int T_CYCLE_NS    = 70,
   parameter int T_CS_END_NS   = 60,
   parameter int T_ADDR_END_NS = 60,
   parameter int T_BSEL_END_NS = 60,
   parameter int T_PULSE_NS    = 55,
   parameter int T_PULSE_L_NS  = 70,
   parameter int T_DSETUP_NS   = 30,
   parameter int T_ASETUP_NS   = 0,
   parameter int T_AHOLD_NS    = 0,
   parameter int T_DHOLD_NS    = 0,
   parameter int T_HIGH_NS     = 10,
   parameter int RUN_LIMIT     = 50
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_req,
   output logic                host_ready,
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic [DATA_W-1:0]   host_data,
   input  logic [DATA_W/8-1:0] host_be,
   output logic                mem_cs_n,
   output logic                mem_we_n,
   output logic                mem_ub_n,
   output logic                mem_lb_n,
   output logic                mem_adv_n,
   input  logic                mem_wait,
   output logic [ADDR_W-1:0]   mem_addr,
   inout  wire  [DATA_W-1:0]   mem_dq
);
   localparam int C_CYC  = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
   localparam int C_CS   = ns_to_cyc(T_CS_END_NS, CLK_PERIOD_NS);
   localparam int C_AW   = ns_to_cyc(T_ADDR_END_NS, CLK_PERIOD_NS);
   localparam int C_BW   = ns_to_cyc(T_BSEL_END_NS, CLK_PERIOD_NS);
   localparam int C_WP   = ns_to_cyc(T_PULSE_NS, CLK_PERIOD_NS);
   localparam int C_WPL  = ns_to_cyc(T_PULSE_L_NS, CLK_PERIOD_NS);
   localparam int C_DW   = ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS);
   localparam int C_AS   = ns_to_cyc(T_ASETUP_NS, CLK_PERIOD_NS);
   localparam int C_AH   = ns_to_cyc(T_AHOLD_NS, CLK_PERIOD_NS);
   localparam int C_DH   = ns_to_cyc(T_DHOLD_NS, CLK_PERIOD_NS);
   localparam int C_HI   = ns_to_cyc(T_HIGH_NS, CLK_PERIOD_NS);

   localparam int SETUP_CYC = C_AS;
   localparam int P_FLOOR   = imax(imax(C_CS - SETUP_CYC, C_AW - SETUP_CYC),
                                   imax(C_BW - SETUP_CYC, imax(C_DW, 1)));
   localparam int PULSE_N   = imax(C_WP, P_FLOOR);
   localparam int PULSE_L   = imax(C_WPL, P_FLOOR);
   localparam int HOLD_CYC  = imax(C_AH, C_DH);
   localparam int RECOV_CYC = imax(C_HI, C_CYC - (SETUP_CYC + PULSE_N + HOLD_CYC + 1));
   localparam int MAX_CYC   = imax(imax(SETUP_CYC, PULSE_L), imax(HOLD_CYC, RECOV_CYC));
   localparam int CNT_W     = $clog2(MAX_CYC + 1);

   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("psram_wr_seq: DATA_W must be 16 (two byte lanes)");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_clk
         $error("psram_wr_seq: CLK_PERIOD_NS must be positive");
      end
      if (ADDR_W < 1 || RUN_LIMIT < 0) begin : g_bad_cfg
         $error("psram_wr_seq: bad ADDR_W or RUN_LIMIT");
      end
   endgenerate

   logic accept, long_w, sel_en, dq_oe;
   logic [DATA_W/8-1:0] lane_sel_n;
   logic unused_wait;

   assign unused_wait = mem_wait;
   assign mem_adv_n   = 1'b1;

   psram_run_tracker #(
      .RUN_LIMIT (RUN_LIMIT),
      .IDLE_CLR  (C_CYC)
   ) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .idle   (host_ready && !host_req),
      .long_o (long_w)
   );

   psram_wr_fsm #(
      .SETUP_CYC (SETUP_CYC),
      .PULSE_N   (PULSE_N),
      .PULSE_L   (PULSE_L),
      .HOLD_CYC  (HOLD_CYC),
      .RECOV_CYC (RECOV_CYC),
      .DV_CYC    (C_DW),
      .CNT_W     (CNT_W)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (host_req),
      .long_i (long_w),
      .ready  (host_ready),
      .accept (accept),
      .cs_n   (mem_cs_n),
      .we_n   (mem_we_n),
      .sel_en (sel_en),
      .dq_oe  (dq_oe)
   );

   psram_wr_bus #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .addr_i     (host_addr),
      .data_i     (host_data),
      .be_i       (host_be),
      .sel_en     (sel_en),
      .dq_oe      (dq_oe),
      .mem_addr   (mem_addr),
      .lane_sel_n (lane_sel_n),
      .mem_dq     (mem_dq)
   );

   assign mem_lb_n = lane_sel_n[0];
   assign mem_ub_n = lane_sel_n[1];

endmodule

// File: rtl/psram_wr_seq_chk.sv
module psram_wr_seq_chk #(
   parameter int ADDR_W    = 23,
   parameter int PULSE_MIN = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_ready,
   input logic              mem_cs_n,
   input logic              mem_we_n,
   input logic              mem_ub_n,
   input logic              mem_lb_n,
   input logic [ADDR_W-1:0] mem_addr
);
   logic [7:0] we_lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         we_lo_cnt <= '0;
      else if (mem_we_n)
         we_lo_cnt <= '0;
      else if (we_lo_cnt != 8'hFF)
         we_lo_cnt <= we_lo_cnt + 1'b1;
   end

   p_we_in_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_cs_n);

   p_cs_leads_we_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(!mem_cs_n));

   p_bus_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |->
         ($stable(mem_addr) && $stable({mem_ub_n, mem_lb_n})));

   p_end_together_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> mem_cs_n);

   p_idle_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs_n |-> (mem_ub_n && mem_lb_n));

   p_pulse_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt >= 8'(PULSE_MIN)));

   p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> !host_ready);

   p_recover_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_cs_n) |=> mem_cs_n);

endmodule

bind psram_wr_seq psram_wr_seq_chk #(
   .ADDR_W    (ADDR_W),
   .PULSE_MIN (PULSE_N)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_ready (host_ready),
   .mem_cs_n   (mem_cs_n),
   .mem_we_n   (mem_we_n),
   .mem_ub_n   (mem_ub_n),
   .mem_lb_n   (mem_lb_n),
   .mem_addr   (mem_addr)
);

// File: tb/psram_wr_seq_test.sv
module psram_wr_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 23;
   localparam int P_NORM     = 6;
   localparam int P_LONG     = 7;
   localparam int DV_MIN     = 3;
   localparam int CS_MIN     = 6;
   localparam int IDLE_CLR   = 7;

   typedef struct {
      logic [ADDR_W-1:0] addr;
      logic [15:0]       data;
      logic [1:0]        be;
      int                pulse;
      int                gap;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_req = 1'b0;
   logic              host_ready;
   logic [ADDR_W-1:0] host_addr = '0;
   logic [15:0]       host_data = '0;
   logic [1:0]        host_be = '0;
   logic              mem_cs_n, mem_we_n, mem_ub_n, mem_lb_n, mem_adv_n;
   logic              mem_wait = 1'b0;
   logic [ADDR_W-1:0] mem_addr;
   wire  [15:0]       mem_dq;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit wait_mode = 0;
   int run_n = 0;
   int last_pulse = 0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   psram_wr_seq uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_req   (host_req),
      .host_ready (host_ready),
      .host_addr  (host_addr),
      .host_data  (host_data),
      .host_be    (host_be),
      .mem_cs_n   (mem_cs_n),
      .mem_we_n   (mem_we_n),
      .mem_ub_n   (mem_ub_n),
      .mem_lb_n   (mem_lb_n),
      .mem_adv_n  (mem_adv_n),
      .mem_wait   (mem_wait),
      .mem_addr   (mem_addr),
      .mem_dq     (mem_dq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // driver: called at a falling edge, returns one falling edge after acceptance
   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                           input logic [1:0] be);
      exp_t e;
      bit b2b;
      b2b = host_req;
      e.addr  = a;
      e.data  = d;
      e.be    = be;
      e.pulse = (run_n >= 50) ? P_LONG : P_NORM;  // R5 / R6 model
      e.gap   = b2b ? last_pulse + 4 : 0;         // R9 spacing model
      if (run_n < 50) run_n++;
      last_pulse = e.pulse;
      sb.push_back(e);
      mem_wait  = wait_mode ? ~mem_wait : 1'b0;
      host_addr = a;
      host_data = d;
      host_be   = be;
      host_req  = 1'b1;
      while (!host_ready) begin
         @(negedge clk);
         if (wait_mode) mem_wait = ~mem_wait;
      end
      @(negedge clk);
   endtask

   task automatic go_idle(input int n);
      host_req = 1'b0;
      while (!host_ready) @(negedge clk);
      repeat (n) @(negedge clk);
      if (n >= IDLE_CLR) run_n = 0;  // R7 model
   endtask

   // monitor
   int   neg_idx = 0;
   int   last_fall = -1;
   logic prev_we = 1'b1, prev_cs = 1'b1;
   int   we_cnt = 0, cs_cnt = 0, dv_cnt = 0;
   bit   lead_ok = 1, inside_ok = 1, ready_ok = 1;
   logic [ADDR_W-1:0] cap_addr;
   logic cap_ub, cap_lb;

   always @(negedge clk) begin
      if (rst_n) begin
         neg_idx++;
         if (!mem_cs_n && prev_cs) begin
            if (sb.size() > 0 && sb[0].gap != 0)
               chk(neg_idx - last_fall == sb[0].gap, "R9", "CS# fall spacing",
                   neg_idx - last_fall, sb[0].gap);
            last_fall = neg_idx;
            cs_cnt = 0; lead_ok = 1; inside_ok = 1; ready_ok = 1; dv_cnt = 0;
         end
         if (!mem_cs_n) begin
            cs_cnt++;
            if (host_ready) ready_ok = 0;
         end
         if (!mem_we_n) begin
            if (prev_we && prev_cs) lead_ok = 0;
            if (mem_cs_n) inside_ok = 0;
            we_cnt++;
            cap_addr = mem_addr;
            cap_ub   = mem_ub_n;
            cap_lb   = mem_lb_n;
            if (sb.size() > 0 && mem_dq == sb[0].data) dv_cnt++;
            else dv_cnt = 0;
         end
         if (mem_we_n && !prev_we) begin
            if (sb.size() == 0) begin
               chk(0, "R9", "unexpected write cycle", 0, 1);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(we_cnt == e.pulse, (e.pulse == P_LONG) ? "R6" : "R5",
                   "WE# pulse cycles", we_cnt, e.pulse);
               chk(mem_cs_n == 1'b1, "R2", "CS# high at end of write", mem_cs_n, 1);
               chk(lead_ok && inside_ok, "R1", "CS# leads and covers WE#",
                   {lead_ok, inside_ok}, 3);
               chk(cs_cnt >= CS_MIN, "R1", "CS# low cycles", cs_cnt, CS_MIN);
               chk(cap_addr == e.addr, "R1", "address", cap_addr, e.addr);
               chk(cap_lb == !e.be[0] && cap_ub == !e.be[1], "R3", "byte selects {ub,lb}",
                   {cap_ub, cap_lb}, {!e.be[1], !e.be[0]});
               chk(dv_cnt >= DV_MIN, "R8", "data valid cycles before end", dv_cnt, DV_MIN);
               chk(mem_dq == e.data, "R8", "data held after end", mem_dq, e.data);
               chk(mem_adv_n == 1'b1, "R4", "ADV# inactive", mem_adv_n, 1);
               chk(ready_ok, "R9", "ready low while CS# low", ready_ok, 1);
               chk(mem_ub_n && mem_lb_n, "R3", "byte selects released",
                   {mem_ub_n, mem_lb_n}, 3);
            end
            we_cnt = 0;
         end
         prev_we = mem_we_n;
         prev_cs = mem_cs_n;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(mem_cs_n && mem_we_n && mem_ub_n && mem_lb_n, "R10", "strobes high in reset",
          {mem_cs_n, mem_we_n, mem_ub_n, mem_lb_n}, 15);
      chk(host_ready == 1'b1, "R10", "ready high in reset", host_ready, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(mem_cs_n && mem_we_n && mem_ub_n && mem_lb_n && host_ready, "R10",
          "idle after reset", {mem_cs_n, mem_we_n, mem_ub_n, mem_lb_n, host_ready}, 31);

      // single writes with each byte-enable pattern (R3, R5, R8)
      do_write(23'h000123, 16'hA55A, 2'b11);
      go_idle(8);
      do_write(23'h7FFFFF, 16'h00C3, 2'b01);
      go_idle(8);
      do_write(23'h400000, 16'h3C00, 2'b10);
      go_idle(8);

      // R4: mem_wait toggling has no effect on a back-to-back pair
      wait_mode = 1;
      do_write(23'h000010, 16'h1234, 2'b11);
      do_write(23'h000011, 16'hFEDC, 2'b11);
      wait_mode = 0;
      mem_wait = 1'b0;
      go_idle(10);

      // R5 / R6: continuous run of 52 writes; writes 51 and 52 use the long pulse
      for (int i = 0; i < 52; i++)
         do_write(ADDR_W'(23'h001000 + i), 16'h5000 ^ 16'(i * 37), 2'(1 + (i % 3)));
      // R7: a six-cycle idle gap keeps the run, the next write stays long
      go_idle(6);
      do_write(23'h002000, 16'h8001, 2'b11);
      // R7: a seven-cycle idle gap clears the run, the next write is normal
      go_idle(7);
      do_write(23'h002001, 16'h7FFE, 2'b11);
      go_idle(4);

      chk(sb.size() == 0, "R9", "all queued writes seen", sb.size(), 0);
      chk(mem_cs_n && mem_ub_n && mem_lb_n && host_ready, "R3", "bus idle at end",
          {mem_cs_n, mem_ub_n, mem_lb_n, host_ready}, 15);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule